// File: doc/BRIEF.md
# Board JTAG Chain Order Selector

This block assembles the board's boundary-scan chain from two local targets, an FPGA and a configuration PROM, and from an upstream and a downstream chain port. A three-bit selector decides which targets sit in the chain and in which order. The options are the FPGA alone, the PROM alone, the FPGA followed by the PROM, the PROM followed by the FPGA, or no local target at all, in which case the upstream data passes straight through. Test clock and mode select are copied unchanged to every target and to the downstream port. Serial data is steered combinationally, so the block adds no register to the scan path.

When the board is the last one in a multi-board chain, a termination input folds the local chain output back onto the return line toward the upstream port. Otherwise the return line carries whatever the downstream board sends back. The selector is read from a system-clock domain. A new ordering takes effect only after the synchronized test clock has stayed low for a configurable number of system clocks, so the chain is never rearranged during a shift. Codes that do not name a topology fall back to feedthrough and raise an error flag.

Top module: `jtag_chain_router`

## Requirements
- R1: After reset the applied topology is feedthrough: both local TDI pins are 1, downstream TDI equals upstream TDI, and `sel_err` is 0.
- R2: `up_tck` and `up_tms` appear unchanged, with no clock delay, on the FPGA, PROM and downstream clock and mode-select outputs.
- R3: Selector code 0 puts only the FPGA in the chain (FPGA TDI = upstream TDI, chain output = FPGA TDO). Code 1 puts only the PROM in the chain, in the same way.
- R4: Code 2 chains the FPGA first: FPGA TDI = upstream TDI, PROM TDI = FPGA TDO, chain output = PROM TDO. Code 3 reverses the order: PROM TDI = upstream TDI, FPGA TDI = PROM TDO, chain output = FPGA TDO.
- R5: Code 4 is feedthrough: the chain output equals upstream TDI combinationally, within the same cycle, with no register in the path.
- R6: A target left out of the chain sees TDI held at 1, and its TDO has no effect on any output.
- R7: The downstream TDI always carries the chain output. With `term_en` = 1 the upstream return `up_tdo` equals the chain output. With `term_en` = 0 it equals `dn_tdo`.
- R8: A selector value is applied only once the synchronized `up_tck` has been low for `IDLE_CYCLES` consecutive system clocks. A change made while TCK toggles, or during a low spell that is too short, leaves the routing unchanged.
- R9: Codes 5, 6 and 7 are applied as feedthrough and set `sel_err` to 1. Applying any code from 0 to 4 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the selector |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 3 | Requested chain topology code |
| term_en | input | 1 | Last-board termination enable |
| up_tck | input | 1 | Test clock from upstream port |
| up_tms | input | 1 | Mode select from upstream port |
| up_tdi | input | 1 | Serial data from upstream port |
| up_tdo | output | 1 | Serial return toward upstream port |
| dn_tck | output | 1 | Test clock to downstream port |
| dn_tms | output | 1 | Mode select to downstream port |
| dn_tdi | output | 1 | Serial data to downstream port |
| dn_tdo | input | 1 | Serial return from downstream port |
| fpga_tck | output | 1 | Test clock to local FPGA |
| fpga_tms | output | 1 | Mode select to local FPGA |
| fpga_tdi | output | 1 | Serial data into local FPGA |
| fpga_tdo | input | 1 | Serial data out of local FPGA |
| prom_tck | output | 1 | Test clock to local PROM |
| prom_tms | output | 1 | Mode select to local PROM |
| prom_tdi | output | 1 | Serial data into local PROM |
| prom_tdo | input | 1 | Serial data out of local PROM |
| sel_err | output | 1 | Last applied selector code was illegal |

## Verification
On every cycle the assertions check several properties. The clock and mode-select copies must match their upstream sources, and the applied topology must stay put in any cycle that follows a synchronized TCK-high sample. Excluded targets must see a high TDI and the feedthrough path must hold. The return line must follow the downstream port when unterminated, and the error flag must track the legality of each applied code. Other behaviours show up only in the bench's scenarios. These are the exact data path of each ordering across every combination of target outputs, and the fact that a change made mid-shift or during a too-short idle spell is withheld and then applied later. They also include the fall-back of codes 5 to 7 and the clearing of the flag.

// File: rtl/jcr_pkg.sv
package jcr_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        MODE_FPGA      = 3'd0,
        MODE_PROM      = 3'd1,
        MODE_FPGA_PROM = 3'd2,
        MODE_PROM_FPGA = 3'd3,
        MODE_FEED      = 3'd4
    } chain_mode_e;

    typedef struct packed {
        chain_mode_e mode;
        logic        err;
    } sel_state_t;

    typedef struct packed {
        logic fpga_tdi;
        logic prom_tdi;
        logic chain_out;
    } route_t;

    function automatic logic sel_legal(input logic [SEL_W-1:0] code);
        return code <= 3'd4;
    endfunction

    function automatic chain_mode_e decode_sel(input logic [SEL_W-1:0] code);
        chain_mode_e m;
        case (code)
            3'd0:    m = MODE_FPGA;
            3'd1:    m = MODE_PROM;
            3'd2:    m = MODE_FPGA_PROM;
            3'd3:    m = MODE_PROM_FPGA;
            default: m = MODE_FEED;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/jcr_tck_sync.sv
module jcr_tck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_raw,
    output logic tck_s
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = tck_raw;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], tck_raw};
        end
    endgenerate

    // reset to "busy" so no sample happens before TCK has really been seen low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign tck_s = sh_q[STAGES-1];
endmodule

// File: rtl/jcr_idle_timer.sv
module jcr_idle_timer #(
    parameter int IDLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_s,
    output logic load_en
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tck_s)
            cnt_d = '0;
        else if (cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a fresh high sample vetoes the load in the same cycle
    assign load_en = (cnt_q == LIMIT) && !tck_s;
endmodule

// File: rtl/jcr_mode_reg.sv
module jcr_mode_reg
    import jcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [SEL_W-1:0] sel_in,
    output chain_mode_e      mode,
    output logic             err
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.mode = decode_sel(sel_in);
            st_d.err  = !sel_legal(sel_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_FEED, err: 1'b0};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign err  = st_q.err;
endmodule

// File: rtl/jcr_chain_mux.sv
module jcr_chain_mux
    import jcr_pkg::*;
(
    input  chain_mode_e mode,
    input  logic        term_en,
    input  logic        up_tdi,
    input  logic        fpga_tdo,
    input  logic        prom_tdo,
    input  logic        dn_tdo,
    output logic        fpga_tdi,
    output logic        prom_tdi,
    output logic        dn_tdi,
    output logic        up_tdo
);
    route_t r;

    always_comb begin
        r = '{fpga_tdi: 1'b1, prom_tdi: 1'b1, chain_out: up_tdi};
        case (mode)
            MODE_FPGA: begin
                r.fpga_tdi  = up_tdi;
                r.chain_out = fpga_tdo;
            end
            MODE_PROM: begin
                r.prom_tdi  = up_tdi;
                r.chain_out = prom_tdo;
            end
            MODE_FPGA_PROM: begin
                r.fpga_tdi  = up_tdi;
                r.prom_tdi  = fpga_tdo;
                r.chain_out = prom_tdo;
            end
            MODE_PROM_FPGA: begin
                r.prom_tdi  = up_tdi;
                r.fpga_tdi  = prom_tdo;
                r.chain_out = fpga_tdo;
            end
            default: ;
        endcase
    end

    assign fpga_tdi = r.fpga_tdi;
    assign prom_tdi = r.prom_tdi;
    assign dn_tdi   = r.chain_out;
    assign up_tdo   = term_en ? r.chain_out : dn_tdo;
endmodule

// File: rtl/jtag_chain_router.sv
module jtag_chain_router
    import jcr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             term_en,
    input  logic             up_tck,
    input  logic             up_tms,
    input  logic             up_tdi,
    output logic             up_tdo,
    output logic             dn_tck,
    output logic             dn_tms,
    output logic             dn_tdi,
    input  logic             dn_tdo,
    output logic             fpga_tck,
    output logic             fpga_tms,
    output logic             fpga_tdi,
    input  logic             fpga_tdo,
    output logic             prom_tck,
    output logic             prom_tms,
    output logic             prom_tdi,
    input  logic             prom_tdo,
    output logic             sel_err
);
    logic        tck_sync;
    logic        load_en;
    chain_mode_e mode_cur;

    assign dn_tck   = up_tck;
    assign dn_tms   = up_tms;
    assign fpga_tck = up_tck;
    assign fpga_tms = up_tms;
    assign prom_tck = up_tck;
    assign prom_tms = up_tms;

    jcr_tck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tck_raw (up_tck),
        .tck_s   (tck_sync)
    );

    jcr_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tck_s   (tck_sync),
        .load_en (load_en)
    );

    jcr_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .sel_in  (sel_in),
        .mode    (mode_cur),
        .err     (sel_err)
    );

    jcr_chain_mux u_mux (
        .mode     (mode_cur),
        .term_en  (term_en),
        .up_tdi   (up_tdi),
        .fpga_tdo (fpga_tdo),
        .prom_tdo (prom_tdo),
        .dn_tdo   (dn_tdo),
        .fpga_tdi (fpga_tdi),
        .prom_tdi (prom_tdi),
        .dn_tdi   (dn_tdi),
        .up_tdo   (up_tdo)
    );
endmodule

// File: rtl/jcr_checker.sv
module jcr_checker
    import jcr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel_in,
    input logic             term_en,
    input logic             up_tck,
    input logic             up_tms,
    input logic             up_tdi,
    input logic             up_tdo,
    input logic             dn_tck,
    input logic             dn_tms,
    input logic             dn_tdi,
    input logic             dn_tdo,
    input logic             fpga_tck,
    input logic             fpga_tms,
    input logic             fpga_tdi,
    input logic             prom_tck,
    input logic             prom_tms,
    input logic             prom_tdi,
    input logic             sel_err,
    input logic             tck_s,
    input logic             load_en,
    input chain_mode_e      mode_q
);
    a_r2_clock_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_tck == up_tck) && (fpga_tck == up_tck) && (prom_tck == up_tck) &&
        (dn_tms == up_tms) && (fpga_tms == up_tms) && (prom_tms == up_tms));

    a_r8_no_reorder_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        tck_s |=> $stable(mode_q));

    a_r9_err_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (sel_in > 3'd4)) |=> (sel_err && (mode_q == MODE_FEED)));

    a_r9_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (sel_in <= 3'd4)) |=> !sel_err);

    a_r6_excluded_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_FPGA) |-> prom_tdi) and
        ((mode_q == MODE_PROM) |-> fpga_tdi) and
        ((mode_q == MODE_FEED) |-> (fpga_tdi && prom_tdi)));

    a_r5_feedthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FEED) |-> (dn_tdi == up_tdi));

    a_r7_unterminated_return: assert property (@(posedge clk) disable iff (!rst_n)
        !term_en |-> (up_tdo == dn_tdo));

    a_r7_terminated_return: assert property (@(posedge clk) disable iff (!rst_n)
        term_en |-> (up_tdo == dn_tdi));
endmodule

bind jtag_chain_router jcr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_in   (sel_in),
    .term_en  (term_en),
    .up_tck   (up_tck),
    .up_tms   (up_tms),
    .up_tdi   (up_tdi),
    .up_tdo   (up_tdo),
    .dn_tck   (dn_tck),
    .dn_tms   (dn_tms),
    .dn_tdi   (dn_tdi),
    .dn_tdo   (dn_tdo),
    .fpga_tck (fpga_tck),
    .fpga_tms (fpga_tms),
    .fpga_tdi (fpga_tdi),
    .prom_tck (prom_tck),
    .prom_tms (prom_tms),
    .prom_tdi (prom_tdi),
    .sel_err  (sel_err),
    .tck_s    (tck_sync),
    .load_en  (load_en),
    .mode_q   (mode_cur)
);

// File: tb/jtag_chain_router_tb.sv
module jtag_chain_router_tb;
    localparam int IDLE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_in = 3'd2;
    logic       term_en = 1'b0;
    logic       up_tck = 1'b0, up_tms = 1'b0, up_tdi = 1'b0;
    logic       dn_tdo = 1'b0, fpga_tdo = 1'b0, prom_tdo = 1'b0;
    logic       up_tdo, dn_tck, dn_tms, dn_tdi;
    logic       fpga_tck, fpga_tms, fpga_tdi, prom_tck, prom_tms, prom_tdi;
    logic       sel_err;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    jtag_chain_router #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .term_en(term_en),
        .up_tck(up_tck), .up_tms(up_tms), .up_tdi(up_tdi), .up_tdo(up_tdo),
        .dn_tck(dn_tck), .dn_tms(dn_tms), .dn_tdi(dn_tdi), .dn_tdo(dn_tdo),
        .fpga_tck(fpga_tck), .fpga_tms(fpga_tms), .fpga_tdi(fpga_tdi), .fpga_tdo(fpga_tdo),
        .prom_tck(prom_tck), .prom_tms(prom_tms), .prom_tdi(prom_tdi), .prom_tdo(prom_tdo),
        .sel_err(sel_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected {up_tdo, dn_tdi, fpga_tdi, prom_tdi} for a code, from R3..R7, R9
    function automatic logic [3:0] model(input int code, input logic ui, ft, pt, dt, te);
        logic fi, pi, co;
        int   m;
        m  = (code > 4) ? 4 : code;
        fi = 1'b1; pi = 1'b1; co = ui;
        case (m)
            0: begin fi = ui; co = ft; end
            1: begin pi = ui; co = pt; end
            2: begin fi = ui; pi = ft; co = pt; end
            3: begin pi = ui; fi = pt; co = ft; end
            default: ;
        endcase
        return {te ? co : dt, co, fi, pi};
    endfunction

    // sweep every data-input combination and compare routing for topology 'code'
    task automatic check_routing(input int code, input string req);
        for (int v = 0; v < 32; v++) begin
            logic [3:0] exp, act;
            @(negedge clk);
            {up_tdi, fpga_tdo, prom_tdo, dn_tdo, term_en} = 5'(v);
            #1;
            exp = model(code, up_tdi, fpga_tdo, prom_tdo, dn_tdo, term_en);
            act = {up_tdo, dn_tdi, fpga_tdi, prom_tdi};
            chk(act == exp, req, $sformatf("routing code %0d vec %0d", code, v),
                8'(act), 8'(exp));
        end
    endtask

    task automatic apply_code(input logic [2:0] code);
        @(negedge clk);
        sel_in = code;
        up_tck = 1'b0;
        repeat (IDLE * 3) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        sel_in = 3'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < 3; v++) begin
            @(negedge clk);
            up_tdi = v[0];
            #1;
            chk({fpga_tdi, prom_tdi, dn_tdi} == {2'b11, up_tdi}, "R1",
                "feedthrough after reset", 8'({fpga_tdi, prom_tdi, dn_tdi}),
                8'({2'b11, up_tdi}));
            chk(sel_err == 1'b0, "R1", "sel_err after reset", 8'(sel_err), 8'h0);
        end
    endtask

    task automatic t_broadcast;
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            {up_tck, up_tms} = 2'(v);
            #1;
            chk({dn_tck, fpga_tck, prom_tck} == {3{up_tck}}, "R2", "tck copies",
                8'({dn_tck, fpga_tck, prom_tck}), 8'({3{up_tck}}));
            chk({dn_tms, fpga_tms, prom_tms} == {3{up_tms}}, "R2", "tms copies",
                8'({dn_tms, fpga_tms, prom_tms}), 8'({3{up_tms}}));
        end
        up_tck = 1'b0;
    endtask

    task automatic t_orders;
        apply_code(3'd0); check_routing(0, "R3 R6 R7");
        apply_code(3'd1); check_routing(1, "R3 R6 R7");
        apply_code(3'd2); check_routing(2, "R4 R7");
        apply_code(3'd3); check_routing(3, "R4 R7");
        apply_code(3'd4); check_routing(4, "R5 R6 R7");
    endtask

    // R8: change during active shifting must be withheld until TCK idles
    task automatic t_busy_hold;
        apply_code(3'd2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            up_tck = i[1];
            if (i == 10) sel_in = 3'd1;
        end
        up_tck = 1'b1;
        check_routing(2, "R8 busy hold");
        up_tck = 1'b0;
        repeat (IDLE * 3) @(negedge clk);
        check_routing(1, "R8 applied after idle");
    endtask

    // R8: a low spell shorter than the window does not apply the code
    task automatic t_short_idle;
        @(negedge clk);
        up_tck = 1'b1;
        repeat (4) @(negedge clk);
        sel_in = 3'd3;
        up_tck = 1'b0;
        repeat (4) @(negedge clk);
        up_tck = 1'b1;
        repeat (4) @(negedge clk);
        check_routing(1, "R8 short idle");
        up_tck = 1'b0;
        repeat (IDLE * 3) @(negedge clk);
        check_routing(3, "R8 long idle");
    endtask

    task automatic t_illegal;
        for (int c = 5; c < 8; c++) begin
            apply_code(3'(c));
            #1;
            chk(sel_err == 1'b1, "R9", $sformatf("flag for code %0d", c), 8'(sel_err), 8'h1);
            check_routing(c, "R9 fallback");
        end
        apply_code(3'd0);
        #1;
        chk(sel_err == 1'b0, "R9", "flag cleared", 8'(sel_err), 8'h0);
        check_routing(0, "R9 legal again");
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        t_reset();
        t_broadcast();
        t_orders();
        t_busy_hold();
        t_short_idle();
        t_illegal();
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule